// File: doc/BRIEF.md
# Two-Wire Register Bank Slave

This block is a slave on a two-wire serial bus that gives a host read and write access to a bank of 8-bit control registers addressed by an 8-bit register pointer. SCL and SDA are oversampled on the system clock. The block detects start, repeated start and stop conditions and matches a 7-bit device address plus a direction bit. It drives SDA only through an open-drain pull-low enable.

A write transaction carries the register pointer in its first byte after the device address. Every later byte lands in the register the pointer selects, and the pointer then steps by one. A read first loads the pointer with a write-direction access. A repeated start with the read address follows, and the slave then streams successive registers until the host answers a byte with no-acknowledge. The pointer keeps its value between transactions.

A small range of registers is read-only. Writes past the end of the bank are accepted on the bus but change nothing. One register holds a self-clearing control bit that restores the whole bank to its defaults. The register contents are presented in parallel to the surrounding logic.

Top module: `twi_regbank_slave`

## Requirements
- R1: After rst_n is released, sda_oe is 0 and register n (0 to NUM_REGS-1) holds its default value, which is ((n*37)+11) mod 128. Register n appears on regs_o[8n+7:8n].
- R2: A start (SDA falling while SCL is high) followed by the byte DCh (device address 6Eh, bit 0 = 0 for write) or DDh (bit 0 = 1 for read) is acknowledged: the slave pulls SDA low during the ninth SCL pulse. A stop (SDA rising while SCL is high) ends the transaction.
- R3: A device address byte other than DCh or DDh is not acknowledged. The slave leaves SDA released and ignores all further bytes until the next start.
- R4: In a write, the byte after the address sets the register pointer. Each following data byte is acknowledged and stored into the pointed register, and the pointer then increments.
- R5: After the pointer is set, a repeated start with DDh makes the slave send the pointed register MSB first, with the pointer incrementing after each byte. Successive bytes return successive registers.
- R6: A host acknowledge (SDA low on the ninth pulse) makes the slave send the next byte. A host no-acknowledge ends the read, and the slave keeps SDA released until the next start.
- R7: The register pointer is kept across a stop, so a later read without a pointer byte continues at the register after the last one accessed.
- R8: Writes to a pointer at or above NUM_REGS are still acknowledged but change no register. Reads from such a pointer return 00h.
- R9: Registers RO_FIRST to RO_LAST (1Ch and 1Dh by default) ignore writes, which are still acknowledged, and keep their default values.
- R10: Writing a byte with bit 7 set to register 12h restores every register, including 12h, to its default. Writing a byte with bit 7 clear to 12h stores the byte like any other register.
- R11: sda_oe changes only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock used to oversample the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Serial clock line as seen at the pad |
| sda_i | input | 1 | Serial data line as seen at the pad |
| sda_oe | output | 1 | When 1, the pad pulls SDA low |
| regs_o | output | NUM_REGS*8 | All register contents, register n at bits 8n+7:8n |

## Verification
The bench builds the block with its defaults: 64 registers, device address 6Eh, read-only registers 1Ch–1Dh and the reset control in register 12h. With these values a burst that starts at register 3Fh runs off the end of the bank within two bytes, so both the ignored write and the 00h read past the end are reached cheaply. The read-only pair and the reset register also sit inside a short burst. The bus runs at a bit period of 40 system clocks, which leaves wide margins around the synchronizer delay. The tests therefore cover protocol order and register effects, not timing-edge races.

// File: rtl/twi_regbank_slave.sv
module twi_regbank_slave #(
  parameter logic [6:0] DEV_ADDR = 7'h6E,
  parameter int NUM_REGS = 64,
  parameter int RST_REG  = 18,
  parameter int RST_BIT  = 7,
  parameter int RO_FIRST = 28,
  parameter int RO_LAST  = 29
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  scl_i,
  input  logic                  sda_i,
  output logic                  sda_oe,
  output logic [NUM_REGS*8-1:0] regs_o
);

  localparam int IW = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1;
  localparam logic [8:0] NREG9 = 9'(NUM_REGS);
  localparam logic [7:0] RO_A = 8'(RO_FIRST);
  localparam logic [7:0] RO_B = 8'(RO_LAST);
  localparam logic [7:0] RST_A = 8'(RST_REG);

  typedef enum logic [2:0] {S_IDLE, S_RX, S_ACK, S_TX, S_MACK} st_t;
  typedef enum logic [1:0] {P_DEV, P_REG, P_DAT} ph_t;

  function automatic logic [7:0] dflt(input int idx);
    return 8'(((idx * 37) + 11) % 128);
  endfunction

  logic [2:0] scl_sh, sda_sh;
  st_t        state;
  ph_t        phase;
  logic [3:0] bitcnt;
  logic [7:0] shreg, ptr;
  logic       rw, mack;
  logic [7:0] regs [NUM_REGS];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      scl_sh <= 3'b111;
      sda_sh <= 3'b111;
    end else begin
      scl_sh <= {scl_sh[1:0], scl_i};
      sda_sh <= {sda_sh[1:0], sda_i};
    end

  wire scl_s    = scl_sh[1];
  wire sda_s    = sda_sh[1];
  wire scl_rise = scl_sh[1] & ~scl_sh[2];
  wire scl_fall = ~scl_sh[1] & scl_sh[2];
  wire start_c  = scl_sh[1] & scl_sh[2] & sda_sh[2] & ~sda_sh[1];
  wire stop_c   = scl_sh[1] & scl_sh[2] & ~sda_sh[2] & sda_sh[1];

  wire [7:0] rx_byte = {shreg[6:0], sda_s};
  wire       ptr_ok  = {1'b0, ptr} < NREG9;
  wire       ptr_ro  = (ptr >= RO_A) && (ptr <= RO_B);
  wire [7:0] rd_byte = ptr_ok ? regs[ptr[IW-1:0]] : 8'h00;

  logic wr_en, wr_ok, soft_rst, idle_w;
  assign wr_en    = (state == S_RX) && scl_rise && (bitcnt == 4'd7) && (phase == P_DAT)
                    && !start_c && !stop_c;
  assign wr_ok    = wr_en && ptr_ok && !ptr_ro;
  assign soft_rst = wr_ok && (ptr == RST_A) && rx_byte[RST_BIT];
  assign idle_w   = (state == S_IDLE);

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n)                          regs[g] <= dflt(g);
      else if (soft_rst)                   regs[g] <= dflt(g);
      else if (wr_ok && ptr == 8'(g))      regs[g] <= rx_byte;
    assign regs_o[g*8 +: 8] = regs[g];
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      state  <= S_IDLE;
      phase  <= P_DEV;
      bitcnt <= '0;
      shreg  <= '0;
      ptr    <= '0;
      rw     <= 1'b0;
      mack   <= 1'b0;
      sda_oe <= 1'b0;
    end else if (start_c) begin
      state  <= S_RX;
      phase  <= P_DEV;
      bitcnt <= '0;
      sda_oe <= 1'b0;
    end else if (stop_c) begin
      state  <= S_IDLE;
      sda_oe <= 1'b0;
    end else begin
      case (state)
        S_RX: begin
          if (scl_rise) begin
            shreg <= rx_byte;
            if (bitcnt == 4'd7) begin
              bitcnt <= 4'd8;
              case (phase)
                P_DEV: begin
                  if (rx_byte[7:1] == DEV_ADDR) begin
                    rw    <= rx_byte[0];
                    phase <= P_REG;
                  end else begin
                    state <= S_IDLE;
                  end
                end
                P_REG: begin
                  ptr   <= rx_byte;
                  phase <= P_DAT;
                end
                default: ptr <= ptr + 8'd1;
              endcase
            end else if (bitcnt < 4'd7) begin
              bitcnt <= bitcnt + 4'd1;
            end
          end else if (scl_fall && bitcnt == 4'd8) begin
            state  <= S_ACK;
            sda_oe <= 1'b1;
            bitcnt <= '0;
          end
        end
        S_ACK: begin
          if (scl_fall) begin
            if (rw) begin
              state  <= S_TX;
              shreg  <= rd_byte;
              sda_oe <= ~rd_byte[7];
              ptr    <= ptr + 8'd1;
              bitcnt <= '0;
            end else begin
              state  <= S_RX;
              sda_oe <= 1'b0;
            end
          end
        end
        S_TX: begin
          if (scl_rise) begin
            bitcnt <= bitcnt + 4'd1;
          end else if (scl_fall) begin
            if (bitcnt == 4'd8) begin
              sda_oe <= 1'b0;
              state  <= S_MACK;
            end else begin
              shreg  <= {shreg[6:0], 1'b0};
              sda_oe <= ~shreg[6];
            end
          end
        end
        S_MACK: begin
          if (scl_rise) begin
            mack <= ~sda_s;
          end else if (scl_fall) begin
            if (mack) begin
              state  <= S_TX;
              shreg  <= rd_byte;
              sda_oe <= ~rd_byte[7];
              ptr    <= ptr + 8'd1;
              bitcnt <= '0;
            end else begin
              state <= S_IDLE;
            end
          end
        end
        default: begin
          sda_oe <= 1'b0;
        end
      endcase
    end

  wire unused_ok = scl_s;

endmodule

// File: rtl/twi_regbank_checker.sv
module twi_regbank_checker #(
  parameter int NUM_REGS = 64,
  parameter int RST_REG  = 18,
  parameter int RO_FIRST = 28,
  parameter int RO_LAST  = 29
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  scl_i,
  input logic                  sda_oe,
  input logic                  idle_w,
  input logic                  wr_en,
  input logic [7:0]            ptr,
  input logic [7:0]            rx_byte,
  input logic [NUM_REGS*8-1:0] regs_o
);

  localparam logic [8:0] NREG9 = 9'(NUM_REGS);
  localparam logic [7:0] DFLT0 = 8'(11);

  AST_SDA_MOVES_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (sda_oe != $past(sda_oe)) |-> !scl_i) else $error("sda_oe moved with SCL high"); // R11

  AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
    idle_w |-> !sda_oe) else $error("SDA driven while idle"); // R3

  AST_OOB_NO_EFFECT: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && ({1'b0, ptr} >= NREG9)) |=> $stable(regs_o)) else $error("out-of-range write changed bank"); // R8

  AST_RO_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && ptr >= 8'(RO_FIRST) && ptr <= 8'(RO_LAST))
      |=> $stable(regs_o[RO_FIRST*8 +: 8]) && $stable(regs_o[RO_LAST*8 +: 8])) else $error("read-only changed"); // R9

  AST_SOFT_RESET: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && ptr == 8'(RST_REG) && rx_byte[7])
      |=> !regs_o[RST_REG*8+7] && regs_o[7:0] == DFLT0) else $error("soft reset missed"); // R10

endmodule

bind twi_regbank_slave twi_regbank_checker #(
  .NUM_REGS(NUM_REGS), .RST_REG(RST_REG), .RO_FIRST(RO_FIRST), .RO_LAST(RO_LAST)
) i_chk (
  .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_oe(sda_oe), .idle_w(idle_w),
  .wr_en(wr_en), .ptr(ptr), .rx_byte(rx_byte), .regs_o(regs_o)
);

// File: tb/test_twi_regbank_slave.sv
`timescale 1ns/1ps
module test_twi_regbank_slave;
  localparam int NREG = 64;
  localparam int Q = 200;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl = 1'b1;
  logic m_low = 1'b0;
  logic sda;
  logic sda_oe;
  logic [NREG*8-1:0] regs_o;
  logic [7:0] model [NREG];
  int n_chk = 0, n_fail = 0, r11_viol = 0;
  logic done = 1'b0;

  always #10 clk = ~clk;
  assign sda = ~(m_low | sda_oe);

  twi_regbank_slave i_twi_regbank_slave (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda),
    .sda_oe(sda_oe), .regs_o(regs_o)
  );

  logic prev_oe = 1'b0;
  always @(negedge clk) begin
    if (rst_n && sda_oe != prev_oe && scl) r11_viol++;
    prev_oe <= sda_oe;
  end

  function automatic logic [7:0] dv(input int n);
    return 8'(((n * 37) + 11) & 127);
  endfunction

  task automatic model_reset();
    for (int i = 0; i < NREG; i++) model[i] = dv(i);
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic chk_bank(input string req);
    int bad = 0;
    for (int i = 0; i < NREG; i++) if (regs_o[i*8 +: 8] !== model[i]) bad++;
    chk(req, bad, 0);
  endtask

  task automatic bit_out(input logic b);
    m_low = !b; #Q; scl = 1'b1; #(2*Q); scl = 1'b0; #Q;
  endtask

  task automatic bit_in(output logic b);
    m_low = 1'b0; #Q; scl = 1'b1; #Q; b = sda; #Q; scl = 1'b0; #Q;
  endtask

  task automatic bus_start();
    m_low = 1'b0; #Q; scl = 1'b1; #Q; m_low = 1'b1; #Q; scl = 1'b0; #Q;
  endtask

  task automatic bus_stop();
    m_low = 1'b1; #Q; scl = 1'b1; #Q; m_low = 1'b0; #(2*Q);
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    logic x;
    for (int i = 7; i >= 0; i--) bit_out(b[i]);
    bit_in(x);
    ack = !x;
  endtask

  task automatic recv_byte(input logic give_ack, output logic [7:0] b);
    logic x;
    for (int i = 7; i >= 0; i--) begin bit_in(x); b[i] = x; end
    bit_out(!give_ack);
  endtask

  task automatic write_burst(input string req, input logic [7:0] rp, input logic [7:0] d [], input int n);
    logic a;
    bus_start();
    send_byte(8'hDC, a); chk({req, " addr ack"}, a, 1);
    send_byte(rp, a);    chk({req, " ptr ack"}, a, 1);
    for (int i = 0; i < n; i++) begin
      send_byte(d[i], a); chk({req, " data ack"}, a, 1);
    end
    bus_stop();
  endtask

  task automatic set_ptr_read(input logic [7:0] rp);
    logic a;
    bus_start();
    send_byte(8'hDC, a); chk("R2 write addr ack", a, 1);
    send_byte(rp, a);    chk("R4 ptr ack", a, 1);
    bus_start();
    send_byte(8'hDD, a); chk("R5 read addr ack", a, 1);
  endtask

  task automatic t_reset();
    chk("R1 sda released after reset", sda_oe, 0);
    chk_bank("R1 defaults");
  endtask

  task automatic t_write_burst();
    logic [7:0] d [] = '{8'h11, 8'h22, 8'h33};
    write_burst("R4", 8'h05, d, 3);
    model[5] = 8'h11; model[6] = 8'h22; model[7] = 8'h33;
    chk("R4 reg 05", regs_o[5*8 +: 8], 8'h11);
    chk("R4 reg 07", regs_o[7*8 +: 8], 8'h33);
    chk_bank("R4 bank");
  endtask

  task automatic t_read_burst();
    logic [7:0] b;
    set_ptr_read(8'h05);
    recv_byte(1'b1, b); chk("R5 first read", b, 8'h11);
    recv_byte(1'b1, b); chk("R6 ack continues", b, 8'h22);
    recv_byte(1'b0, b); chk("R5 third read", b, 8'h33);
    #Q; chk("R6 released after nack", sda_oe, 0);
    bus_stop();
  endtask

  task automatic t_pointer_persist();
    logic a;
    logic [7:0] b;
    bus_start();
    send_byte(8'hDD, a); chk("R2 read addr ack", a, 1);
    recv_byte(1'b0, b);  chk("R7 continues at 08", b, model[8]);
    bus_stop();
  endtask

  task automatic t_wrong_addr();
    logic a;
    bus_start();
    send_byte(8'hA0, a); chk("R3 foreign addr nack", a, 0);
    send_byte(8'h05, a); chk("R3 ignored byte", a, 0);
    send_byte(8'hEE, a); chk("R3 ignored data", a, 0);
    bus_stop();
    bus_start();
    send_byte(8'hDE, a); chk("R3 neighbour addr nack", a, 0);
    bus_stop();
    chk_bank("R3 bank unchanged");
  endtask

  task automatic t_read_only();
    logic [7:0] d [] = '{8'hFF, 8'hFF, 8'h5A};
    logic [7:0] b;
    write_burst("R9", 8'h1C, d, 3);
    model[30] = 8'h5A;
    chk("R9 reg 1C", regs_o[28*8 +: 8], dv(28));
    chk("R9 reg 1D", regs_o[29*8 +: 8], dv(29));
    chk("R9 reg 1E written", regs_o[30*8 +: 8], 8'h5A);
    set_ptr_read(8'h1C);
    recv_byte(1'b0, b); chk("R9 read back", b, dv(28));
    bus_stop();
  endtask

  task automatic t_out_of_range();
    logic [7:0] d [] = '{8'h77, 8'h88, 8'h99};
    logic [7:0] b;
    write_burst("R8", 8'h3F, d, 3);
    model[63] = 8'h77;
    chk("R8 last reg written", regs_o[63*8 +: 8], 8'h77);
    chk_bank("R8 rest unchanged");
    set_ptr_read(8'h3F);
    recv_byte(1'b1, b); chk("R8 last reg read", b, 8'h77);
    recv_byte(1'b0, b); chk("R8 read past end", b, 8'h00);
    bus_stop();
  endtask

  task automatic t_soft_reset();
    logic [7:0] d0 [] = '{8'h40};
    logic [7:0] d1 [] = '{8'h80};
    write_burst("R10", 8'h12, d0, 1);
    model[18] = 8'h40;
    chk("R10 plain store", regs_o[18*8 +: 8], 8'h40);
    chk_bank("R10 before reset");
    write_burst("R10", 8'h12, d1, 1);
    model_reset();
    chk("R10 reg 05 restored", regs_o[5*8 +: 8], dv(5));
    chk_bank("R10 all defaults");
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    model_reset();
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    t_reset();
    t_write_burst();
    t_read_burst();
    t_pointer_persist();
    t_wrong_addr();
    t_read_only();
    t_out_of_range();
    t_soft_reset();
    chk("R11 sda_oe changes only with SCL low", r11_viol, 0);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule